// File: doc/BRIEF.md
# Scanned Keypad Event Port

This block scans a key matrix of up to about seventy keys and presents the result to a processor as one 8-bit read-only port. It drives one row at a time, lets the columns settle, and samples them. A press counts only after it has been seen on two scans of its row in a row. Each new accepted press turns into a key code, and that code is latched into the port.

The port reads 0xFF while no event is pending. When the processor reads the port, it pulses a select input for one clock. That read clears the port back to 0xFF and starts a fixed-length beep pulse. Holding a key down produces one event and no repeats. A key that is released before the read still leaves its code waiting in the port.

Top module: `keyScanPort`

## Requirements
- R1: `rowDrive` is one-hot and active high. Row 0 is driven from reset. Each row stays driven for SETTLE_CYCLES clocks, and the rows advance in ascending order, wrapping from NUM_ROWS-1 back to 0.
- R2: Bit c of `colIn` high means the key at column c of the driven row is pressed. An accepted press latches the code row*NUM_COLS+col into `portData`, so row 0 column 0 gives code 0. Every code is below 0xFF.
- R3: `portData` is 0xFF after reset. It keeps its value until a press is accepted or a read occurs.
- R4: A read is `portSel` high for one clock. On the next clock `portData` is 0xFF, unless a new press was accepted in the same clock.
- R5: `beep` is low after reset. Each read makes `beep` high for exactly BEEP_CYCLES clocks, starting on the clock after the read.
- R6: A key that stays held produces no further event after its first one, including after the read.
- R7: A key released before the read leaves its code readable in `portData`.
- R8: Columns are sampled only on the last clock of a row's drive window. A press that is visible only earlier in the window is ignored.
- R9: A press must be seen on two consecutive scans of its row before it is accepted. A press seen on a single scan produces no code.
- R10: If several keys in one row become accepted at the same sample, the lowest column wins. A newly accepted press overwrites a code that has not been read yet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| colIn | input | NUM_COLS | Column sense lines, high = pressed |
| portSel | input | 1 | One-clock read strobe from the processor |
| rowDrive | output | NUM_ROWS | One-hot row drive |
| portData | output | 8 | Key code, or 0xFF when no event is pending |
| beep | output | 1 | Acknowledge pulse after each read |

## Verification
Every one of the seventy keys is pressed alone. Each press is checked against the arithmetic code, which separates errors in row scaling from errors in column offset. Further patterns cover a long hold, a release before the read, and two keys in one row pressed together. These separate one-shot detection from auto-repeat, latching from live mirroring, and the priority order. Presses timed against the observed `rowDrive` check two things: that a press seen on one scan only is rejected, and that activity early in the settle window is ignored.

// File: rtl/keyScanPkg.sv
package keyScanPkg;
  // strobes from scan control to the datapath
  typedef struct packed {
    logic sample;     // take the column sample of the current row
    logic clearPort;  // processor read: return port to idle
  } scanStrobes_t;

  localparam logic [7:0] IDLE_CODE = 8'hFF;
endpackage

// File: rtl/keyScanCtrl.sv
module keyScanCtrl
  import keyScanPkg::*;
#(
  parameter int NUM_ROWS      = 10,
  parameter int SETTLE_CYCLES = 4,
  parameter int BEEP_CYCLES   = 8,
  localparam int ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int SET_W  = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1,
  localparam int BEEP_W = $clog2(BEEP_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                portSel,
  output logic [ROW_W-1:0]    rowIdx,
  output logic [NUM_ROWS-1:0] rowDrive,
  output scanStrobes_t        strobes,
  output logic                beep
);
  localparam logic [SET_W-1:0]  SETTLE_LAST = SET_W'(SETTLE_CYCLES - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST    = ROW_W'(NUM_ROWS - 1);
  localparam logic [BEEP_W-1:0] BEEP_LOAD   = BEEP_W'(BEEP_CYCLES);

  logic [SET_W-1:0]  settleCnt;
  logic [BEEP_W-1:0] beepCnt;
  logic              lastSettle;

  assign lastSettle = (settleCnt == SETTLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settleCnt <= '0;
      rowIdx    <= '0;
    end else if (lastSettle) begin
      settleCnt <= '0;
      rowIdx    <= (rowIdx == ROW_LAST) ? '0 : rowIdx + 1'b1;
    end else begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              beepCnt <= '0;
    else if (portSel)        beepCnt <= BEEP_LOAD;
    else if (beepCnt != '0)  beepCnt <= beepCnt - 1'b1;
  end

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_rowDrv
    assign rowDrive[g] = (rowIdx == ROW_W'(g));
  end

  assign beep              = (beepCnt != '0);
  assign strobes.sample    = lastSettle;
  assign strobes.clearPort = portSel;
endmodule

// File: rtl/keyScanData.sv
module keyScanData
  import keyScanPkg::*;
#(
  parameter int NUM_ROWS = 10,
  parameter int NUM_COLS = 7,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_COLS-1:0] colIn,
  input  logic [ROW_W-1:0]    rowIdx,
  input  scanStrobes_t        strobes,
  output logic                keyFound,
  output logic [7:0]          portData
);
  logic [NUM_COLS-1:0] lastScan [NUM_ROWS];
  logic [NUM_COLS-1:0] accepted [NUM_ROWS];
  logic [NUM_COLS-1:0] confirmed, newPress;
  logic [7:0]          keyCode;

  // seen now and on the previous scan of this row
  assign confirmed = colIn & lastScan[rowIdx];
  assign newPress  = confirmed & ~accepted[rowIdx];

  // lowest column wins: scan from the top so the lowest is assigned last
  always_comb begin
    keyCode = 8'h00;
    for (int c = NUM_COLS - 1; c >= 0; c--) begin
      if (newPress[c]) keyCode = 8'(rowIdx) * 8'(NUM_COLS) + 8'(c);
    end
  end

  assign keyFound = strobes.sample && (newPress != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        lastScan[r] <= '0;
        accepted[r] <= '0;
      end
    end else if (strobes.sample) begin
      lastScan[rowIdx] <= colIn;
      accepted[rowIdx] <= confirmed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 portData <= IDLE_CODE;
    else if (keyFound)          portData <= keyCode;
    else if (strobes.clearPort) portData <= IDLE_CODE;
  end
endmodule

// File: rtl/keyScanPort.sv
module keyScanPort
  import keyScanPkg::*;
#(
  parameter int NUM_ROWS      = 10,
  parameter int NUM_COLS      = 7,
  parameter int SETTLE_CYCLES = 4,
  parameter int BEEP_CYCLES   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_COLS-1:0] colIn,
  input  logic                portSel,
  output logic [NUM_ROWS-1:0] rowDrive,
  output logic [7:0]          portData,
  output logic                beep
);
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

  initial begin
    if (NUM_ROWS * NUM_COLS > 255) $error("key count must stay below 0xFF");
  end

  logic [ROW_W-1:0] rowIdx;
  scanStrobes_t     strobes;
  logic             keyFound;

  keyScanCtrl #(
    .NUM_ROWS(NUM_ROWS), .SETTLE_CYCLES(SETTLE_CYCLES), .BEEP_CYCLES(BEEP_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .portSel(portSel),
    .rowIdx(rowIdx), .rowDrive(rowDrive), .strobes(strobes), .beep(beep)
  );

  keyScanData #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .colIn(colIn), .rowIdx(rowIdx),
    .strobes(strobes), .keyFound(keyFound), .portData(portData)
  );
endmodule

// File: rtl/keyScanPort_chk.sv
module keyScanPort_chk #(
  parameter int NUM_ROWS = 10,
  parameter int NUM_COLS = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                portSel,
  input logic                keyFound,
  input logic [NUM_ROWS-1:0] rowDrive,
  input logic [7:0]          portData,
  input logic                beep
);
  p_row_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rowDrive) == 1);

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (portData == 8'hFF) || (portData < 8'(NUM_ROWS * NUM_COLS)));

  p_port_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!portSel && !keyFound) |=> $stable(portData));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (portSel && !keyFound) |=> (portData == 8'hFF));

  p_read_beeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    portSel |=> beep);

  p_beep_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beep) |-> $past(portSel));
endmodule

bind keyScanPort keyScanPort_chk #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .portSel(portSel), .keyFound(keyFound),
  .rowDrive(rowDrive), .portData(portData), .beep(beep)
);

// File: tb/keyScanPort_tb.sv
module keyScanPort_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 10;
  localparam int NC = 7;
  localparam int ST = 4;
  localparam int BP = 8;
  localparam int FRAME = NR * ST;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] colIn;
  logic          portSel = 1'b0;
  logic [NR-1:0] rowDrive;
  logic [7:0]    portData;
  logic          beep;
  logic [NC-1:0] keyMat [NR];

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keyScanPort #(.NUM_ROWS(NR), .NUM_COLS(NC), .SETTLE_CYCLES(ST), .BEEP_CYCLES(BP)) u_dut (
    .clk(clk), .rst_n(rst_n), .colIn(colIn), .portSel(portSel),
    .rowDrive(rowDrive), .portData(portData), .beep(beep)
  );

  // matrix model: driven row connects its pressed keys to the columns
  always_comb begin
    colIn = '0;
    for (int r = 0; r < NR; r++) if (rowDrive[r]) colIn = colIn | keyMat[r];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearKeys();
    for (int r = 0; r < NR; r++) keyMat[r] = '0;
  endtask

  task automatic waitFrames(input int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  // one-clock read; returns to a negedge after the read edge
  task automatic doRead();
    @(negedge clk);
    portSel = 1'b1;
    @(negedge clk);
    portSel = 1'b0;
  endtask

  initial begin
    clearKeys();
    repeat (3) @(negedge clk);
    check(portData == 8'hFF, "R3 reset port", portData, 255);
    check(beep == 1'b0, "R5 reset beep", beep, 0);
    check(rowDrive == NR'(1), "R1 reset row", rowDrive, 1);
    rst_n = 1'b1;

    // R1: row k/ST drive after k edges
    for (int k = 1; k <= 2 * FRAME; k++) begin
      @(negedge clk);
      check(rowDrive == NR'(1) << ((k / ST) % NR), "R1 row sequence",
            rowDrive, 1 << ((k / ST) % NR));
    end

    // R2 + R4 + R5: every key alone
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < NC; c++) begin
        keyMat[r][c] = 1'b1;
        waitFrames(3);
        check(portData == 8'(r * NC + c), "R2 key code", portData, r * NC + c);
        doRead();
        check(portData == 8'hFF, "R4 read clears", portData, 255);
        keyMat[r][c] = 1'b0;
        waitFrames(2);
      end
    end

    // R5: beep length
    begin
      int highs = 0;
      @(negedge clk);
      portSel = 1'b1;
      @(negedge clk);
      portSel = 1'b0;
      for (int i = 0; i < BP + 6; i++) begin
        if (beep) highs++;
        @(negedge clk);
      end
      check(highs == BP, "R5 beep length", highs, BP);
      check(beep == 1'b0, "R5 beep ends", beep, 0);
    end

    // R6: held key, one event only
    keyMat[3][4] = 1'b1;
    waitFrames(3);
    check(portData == 8'(3 * NC + 4), "R6 first event", portData, 3 * NC + 4);
    doRead();
    waitFrames(4);
    check(portData == 8'hFF, "R6 no repeat while held", portData, 255);
    keyMat[3][4] = 1'b0;
    waitFrames(2);

    // R7: release before read
    keyMat[6][1] = 1'b1;
    waitFrames(3);
    keyMat[6][1] = 1'b0;
    waitFrames(3);
    check(portData == 8'(6 * NC + 1), "R7 code kept after release", portData, 6 * NC + 1);
    doRead();
    check(portData == 8'hFF, "R7 read clears", portData, 255);

    // R10: lowest column in a row wins
    keyMat[5][5] = 1'b1;
    keyMat[5][2] = 1'b1;
    waitFrames(3);
    check(portData == 8'(5 * NC + 2), "R10 lowest column wins", portData, 5 * NC + 2);
    // R10: a new press overwrites the pending code
    keyMat[8][0] = 1'b1;
    waitFrames(3);
    check(portData == 8'(8 * NC), "R10 overwrite pending", portData, 8 * NC);
    doRead();
    clearKeys();
    waitFrames(2);

    // R9: press seen on a single scan only
    @(posedge rowDrive[4]);
    @(negedge clk);
    keyMat[4][3] = 1'b1;
    @(negedge rowDrive[4]);
    keyMat[4][3] = 1'b0;
    waitFrames(3);
    check(portData == 8'hFF, "R9 single scan rejected", portData, 255);

    // R8: activity only early in the window, on two consecutive scans
    for (int s = 0; s < 2; s++) begin
      @(posedge rowDrive[2]);
      @(negedge clk);
      keyMat[2][6] = 1'b1;
      @(negedge clk);
      keyMat[2][6] = 1'b0;
    end
    waitFrames(3);
    check(portData == 8'hFF, "R8 early activity ignored", portData, 255);

    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(negedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule